// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block sends bytes over a clocked serial link, least significant bit first. Software writes a byte into a holding register and then clears the empty flag in the status register. The block answers by moving the byte into its shift register and setting the empty flag again, so the holding register can take the next byte while the current one is still being shifted. When the flag is still clear at the sample edge of the last bit of a frame, the next byte follows with no gap. When the flag is set at that edge, the frame ends, the transmit-end flag rises, and the data line keeps the level of the last bit.

The serial clock comes from one of two sources. The block can make it from the system clock, using a half-period of `HALF_DIV` system clocks. It can also follow an external clock, which passes through a two-flop synchronizer with edge detection. Data changes after a falling edge and is meant to be sampled on the rising edge. The block has two level interrupt requests, holding-register-empty and transmit-end, and each one has its own enable bit.

Top module: `sync_ser_tx`

## Requirements
- R1: After synchronous reset: `flag_empty`=1, `flag_end`=1, `txd`=1, `sclk_out`=1, both interrupt requests 0.
- R2: A write to the status address (2) with data bit 0 equal to 0 clears the empty flag on that clock edge. On the following edge the holding register is copied into the shift register and the empty flag returns to 1, so `flag_empty` reads 0 for exactly one cycle.
- R3: `irq_empty` is 1 exactly when the empty flag is 1 and control bit 0 (empty interrupt enable, control address 1) is 1.
- R4: Bits leave on `txd` from bit 0 to bit 7. `txd` only changes while the generated serial clock is low, so it is stable at every rising edge.
- R5: In internal-clock mode (control bit 2 = 0) a single frame produces exactly 8 rising edges on `sclk_out`. Consecutive rising edges are 2*`HALF_DIV` system clocks apart.
- R6: If the empty flag is 0 when the rising edge of bit 7 occurs, the next byte is loaded and its bits follow without a gap: 16 evenly spaced rising edges for two queued bytes.
- R7: If the empty flag is 1 at the rising edge of bit 7, the end flag is set. `txd` then holds the level of bit 7 and `sclk_out` rests high.
- R8: `irq_end` is 1 exactly when the end flag is 1 and control bit 1 (end interrupt enable) is 1.
- R9: The status write that clears the empty flag also clears the end flag on the same edge.
- R10: In external-clock mode (control bit 2 = 1) `sclk_out` stays high. `txd` advances to the next bit only after a synchronized falling edge of `sclk_in` that follows a rising edge within the frame, and it does not move within one system clock of that fall.
- R11: Writing only the holding register (address 0) starts no transmission: no serial clock pulses, `txd` unchanged, empty flag still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 holding, 1 control, 2 status |
| wr_data | input | DW | Write data |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Generated serial clock, high when idle |
| txd | output | 1 | Serial data output |
| flag_empty | output | 1 | Holding register empty flag |
| flag_end | output | 1 | Transmit-end flag |
| irq_empty | output | 1 | Holding-register-empty interrupt request |
| irq_end | output | 1 | Transmit-end interrupt request |

## Verification
The bench sends a sweep of byte values, including all-zeros and all-ones. A receiver model in the bench rebuilds each byte from `txd` at every rising edge of `sclk_out`. A bit-order or bit-count error shows up as a mismatched byte or a pulse count other than eight. Two queued bytes test the sample point at bit 7: sampling too early or too late shows up as a gap in the edge spacing, a lost second byte, or a spurious end flag. After each frame the bench checks the resting level of the data line, which a design would get wrong if it returned `txd` high or let the clock fall again. In external mode it checks that an unpaired leading fall is ignored and that the synchronizer delay is present.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_HOLD = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  localparam int CTRL_EMPTY_IE = 0;
  localparam int CTRL_END_IE   = 1;
  localparam int CTRL_EXT_CLK  = 2;
  localparam int STAT_EMPTY    = 0;

  typedef struct packed {
    logic ext_clk;
    logic end_ie;
    logic empty_ie;
  } ctl_t;
endpackage

// File: rtl/sst_regs.sv
module sst_regs
  import sst_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              load_pulse,
  input  logic              end_pulse,
  output logic [DW-1:0]     hold_q,
  output ctl_t              ctl_q,
  output logic              empty_q,
  output logic              end_q,
  output logic              irq_empty,
  output logic              irq_end
);
  logic clr_req;
  logic hold_we;
  ctl_t ctl_nx;
  logic empty_nx;
  logic end_nx;

  always_comb begin
    hold_we = wr_en && (wr_addr == ADDR_HOLD);
    clr_req = wr_en && (wr_addr == ADDR_STAT) && !wr_data[STAT_EMPTY];
    ctl_nx  = ctl_q;
    if (wr_en && (wr_addr == ADDR_CTRL)) begin
      ctl_nx.empty_ie = wr_data[CTRL_EMPTY_IE];
      ctl_nx.end_ie   = wr_data[CTRL_END_IE];
      ctl_nx.ext_clk  = wr_data[CTRL_EXT_CLK];
    end
    if (load_pulse)   empty_nx = 1'b1;
    else if (clr_req) empty_nx = 1'b0;
    else              empty_nx = empty_q;
    if (clr_req)        end_nx = 1'b0;
    else if (end_pulse) end_nx = 1'b1;
    else                end_nx = end_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      ctl_q     <= '0;
      empty_q   <= 1'b1;
      end_q     <= 1'b1;
      irq_empty <= 1'b0;
      irq_end   <= 1'b0;
    end else begin
      if (hold_we) hold_q <= wr_data;
      ctl_q     <= ctl_nx;
      empty_q   <= empty_nx;
      end_q     <= end_nx;
      irq_empty <= empty_nx & ctl_nx.empty_ie;
      irq_end   <= end_nx & ctl_nx.end_ie;
    end
  end

  AST_LOAD_REFILLS: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> empty_q); // R2
  AST_IRQ_EMPTY_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_empty |-> (empty_q && ctl_q.empty_ie)); // R3
  AST_END_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    end_q |-> empty_q); // R7
  AST_IRQ_END_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_end |-> (end_q && ctl_q.end_ie)); // R8
  AST_CLEAR_DROPS_END: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_STAT && !wr_data[STAT_EMPTY]) |=> !end_q); // R9
endmodule

// File: rtl/sst_clkgen.sv
module sst_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_sel,
  input  logic run,
  input  logic start,
  input  logic sclk_in,
  output logic sclk_out,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          tick;
  logic          s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= sclk_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign tick = !ext_sel && run && !start && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || ext_sel) begin
      sclk_q <= 1'b1;
      cnt_q  <= '0;
    end else if (start) begin
      sclk_q <= 1'b0;
      cnt_q  <= '0;
    end else if (run) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        sclk_q <= ~sclk_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      sclk_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  always_comb begin
    if (ext_sel) begin
      rise_ev = s2_q & ~s3_q;
      fall_ev = ~s2_q & s3_q;
    end else begin
      rise_ev = tick & ~sclk_q;
      fall_ev = tick & sclk_q;
    end
  end

  assign sclk_out = sclk_q;

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !run |-> sclk_q); // R7
  AST_HALF_PERIOD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run && !ext_sel && !start && cnt_q != LAST) |=> $stable(sclk_q)); // R5
  AST_EXT_SCLK_HIGH: assert property (@(posedge clk) disable iff (rst)
    ext_sel |=> sclk_q); // R10
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          empty_flag,
  input  logic [DW-1:0] hold_data,
  input  logic          rise_ev,
  input  logic          fall_ev,
  output logic          busy,
  output logic          start,
  output logic          load_pulse,
  output logic          end_pulse,
  output logic          txd
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BW-1:0] LAST = BW'(DW - 1);

  logic [DW-1:0] shreg_q;
  logic [BW-1:0] cnt_q;
  logic [BW-1:0] cnt_nx;
  logic          seen_rise_q;
  logic          last_rise;
  logic          chain;

  always_comb begin
    start      = !busy && !empty_flag;
    last_rise  = busy && rise_ev && (cnt_q == LAST);
    chain      = last_rise && !empty_flag;
    end_pulse  = last_rise && empty_flag;
    load_pulse = start || chain;
    cnt_nx     = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      shreg_q     <= '0;
      cnt_q       <= '0;
      seen_rise_q <= 1'b0;
      txd         <= 1'b1;
    end else if (start) begin
      busy        <= 1'b1;
      shreg_q     <= hold_data;
      cnt_q       <= '0;
      seen_rise_q <= 1'b0;
      txd         <= hold_data[0];
    end else if (busy) begin
      if (rise_ev) begin
        seen_rise_q <= 1'b1;
        if (end_pulse) busy <= 1'b0;
        if (chain) shreg_q <= hold_data;
      end else if (fall_ev && seen_rise_q) begin
        seen_rise_q <= 1'b0;
        cnt_q       <= cnt_nx;
        txd         <= shreg_q[cnt_nx];
      end
    end
  end

  AST_TXD_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(txd) |-> $past(start || (busy && fall_ev))); // R4
  AST_FRAME_ENDS_AT_LAST: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(cnt_q) == LAST); // R7
  AST_NO_EDGE_COLLIDE: assert property (@(posedge clk) disable iff (rst)
    !(rise_ev && fall_ev)); // R4
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
  import sst_pkg::*;
#(
  parameter int DW       = 8,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              txd,
  output logic              flag_empty,
  output logic              flag_end,
  output logic              irq_empty,
  output logic              irq_end
);
  logic [DW-1:0] hold_q;
  ctl_t          ctl_q;
  logic          busy;
  logic          start;
  logic          load_pulse;
  logic          end_pulse;
  logic          rise_ev;
  logic          fall_ev;

  sst_regs #(.DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .load_pulse (load_pulse),
    .end_pulse  (end_pulse),
    .hold_q     (hold_q),
    .ctl_q      (ctl_q),
    .empty_q    (flag_empty),
    .end_q      (flag_end),
    .irq_empty  (irq_empty),
    .irq_end    (irq_end)
  );

  sst_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .ext_sel  (ctl_q.ext_clk),
    .run      (busy),
    .start    (start),
    .sclk_in  (sclk_in),
    .sclk_out (sclk_out),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev)
  );

  sst_shifter #(.DW(DW)) u_shifter (
    .clk        (clk),
    .rst        (rst),
    .empty_flag (flag_empty),
    .hold_data  (hold_q),
    .rise_ev    (rise_ev),
    .fall_ev    (fall_ev),
    .busy       (busy),
    .start      (start),
    .load_pulse (load_pulse),
    .end_pulse  (end_pulse),
    .txd        (txd)
  );
endmodule

// File: tb/test_sync_ser_tx.sv
module test_sync_ser_tx;
  localparam int HD = 4;
  localparam int PER = 2 * HD;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       sclk_in = 1'b1;
  logic       sclk_out, txd, flag_empty, flag_end, irq_empty, irq_end;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  sync_ser_tx #(.DW(8), .HALF_DIV(HD)) i_sync_ser_tx (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .txd(txd), .flag_empty(flag_empty),
    .flag_end(flag_end), .irq_empty(irq_empty), .irq_end(irq_end)
  );

  // receiver model
  bit          mon_clr = 1'b0;
  int          cyc = 0;
  int          nrise, last_t, min_per, max_per, bad_edge;
  logic [15:0] rx_bits;
  logic        sclk_prev, txd_prev;

  always @(negedge clk) begin
    cyc++;
    if (rst || mon_clr) begin
      nrise = 0; last_t = -1; min_per = 1 << 20; max_per = 0;
      bad_edge = 0; rx_bits = '0;
    end else begin
      if (sclk_out && !sclk_prev) begin
        rx_bits = {txd, rx_bits[15:1]};
        nrise++;
        if (last_t >= 0) begin
          if (cyc - last_t < min_per) min_per = cyc - last_t;
          if (cyc - last_t > max_per) max_per = cyc - last_t;
        end
        last_t = cyc;
      end
      if (txd !== txd_prev && sclk_out && sclk_prev) bad_edge++;
    end
    sclk_prev = sclk_out;
    txd_prev  = txd;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_mon();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  task automatic wait_end(input string req);
    int n = 0;
    while (!flag_end && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(flag_end == 1'b1, req, flag_end, 1);
    repeat (3 * HD) @(negedge clk);
  endtask

  task automatic one_frame(input logic [7:0] d);
    clear_mon();
    wr(2'd0, d);
    wr(2'd2, 8'h00);
    check(flag_empty == 1'b0, "R2 empty cleared", flag_empty, 0);
    check(flag_end == 1'b0, "R9 end cleared", flag_end, 0);
    check(irq_empty == 1'b0, "R3 irq_empty low", irq_empty, 0);
    @(negedge clk);
    check(flag_empty == 1'b1, "R2 empty refilled", flag_empty, 1);
    check(irq_empty == 1'b1, "R3 irq_empty high", irq_empty, 1);
    wait_end("R7 end flag");
    check(nrise == 8, "R5 pulse count", nrise, 8);
    check(rx_bits[15:8] == d, "R4 byte", rx_bits[15:8], d);
    check(min_per == PER && max_per == PER, "R5 spacing", max_per, PER);
    check(bad_edge == 0, "R4 txd stable at high clock", bad_edge, 0);
    check(txd == d[7], "R7 hold bit 7", txd, d[7]);
    check(sclk_out == 1'b1, "R7 sclk rests high", sclk_out, 1);
    check(irq_end == 1'b1, "R8 irq_end high", irq_end, 1);
  endtask

  task automatic ext_frame(input logic [7:0] d);
    wr(2'd0, d);
    wr(2'd2, 8'h00);
    repeat (3) @(negedge clk);
    check(txd == d[0], "R10 first bit", txd, d[0]);
    for (int i = 0; i < 8; i++) begin
      sclk_in = 1'b0;
      @(negedge clk);
      if (i > 0) check(txd == d[i-1], "R10 synchronizer delay", txd, d[i-1]);
      repeat (5) @(negedge clk);
      check(txd == d[i], "R10 bit after fall", txd, d[i]);
      check(sclk_out == 1'b1, "R10 sclk_out high", sclk_out, 1);
      sclk_in = 1'b1;
      repeat (6) @(negedge clk);
    end
    check(flag_end == 1'b1, "R10 end after eighth rise", flag_end, 1);
    check(txd == d[7], "R10 hold bit 7", txd, d[7]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(flag_empty == 1'b1, "R1 empty", flag_empty, 1);
    check(flag_end == 1'b1, "R1 end", flag_end, 1);
    check(txd == 1'b1, "R1 txd", txd, 1);
    check(sclk_out == 1'b1, "R1 sclk", sclk_out, 1);
    check(irq_empty == 1'b0 && irq_end == 1'b0, "R1 irqs", {irq_empty, irq_end}, 0);

    // R11 holding write alone
    clear_mon();
    wr(2'd0, 8'h3C);
    repeat (40) @(negedge clk);
    check(nrise == 0, "R11 no pulses", nrise, 0);
    check(flag_empty == 1'b1, "R11 empty kept", flag_empty, 1);
    check(txd == 1'b1, "R11 txd kept", txd, 1);

    // both interrupts enabled, internal clock
    wr(2'd1, 8'h03);
    check(irq_empty == 1'b1, "R3 enable", irq_empty, 1);
    check(irq_end == 1'b1, "R8 enable", irq_end, 1);

    one_frame(8'h00);
    one_frame(8'hFF);
    one_frame(8'hA5);
    one_frame(8'h5A);
    one_frame(8'h01);
    one_frame(8'h80);
    for (int i = 0; i < 16; i++) one_frame(8'(i * 37 + 11));

    // R6 back-to-back frames
    clear_mon();
    wr(2'd0, 8'hC3);
    wr(2'd2, 8'h00);
    repeat (2) @(negedge clk);
    wr(2'd0, 8'h96);
    wr(2'd2, 8'h00);
    check(flag_end == 1'b0, "R6 no end while queued", flag_end, 0);
    wait_end("R6 end after second");
    check(nrise == 16, "R6 pulse count", nrise, 16);
    check(rx_bits == 16'h96C3, "R6 bytes", rx_bits, 16'h96C3);
    check(min_per == PER && max_per == PER, "R6 no gap", max_per, PER);
    check(txd == 1'b1, "R6 hold bit 7", txd, 1);

    // R8/R3 disabled enables
    wr(2'd1, 8'h00);
    check(irq_end == 1'b0, "R8 disabled", irq_end, 0);
    check(irq_empty == 1'b0, "R3 disabled", irq_empty, 0);
    check(flag_end == 1'b1 && flag_empty == 1'b1, "R8 flags kept", {flag_end, flag_empty}, 3);
    wr(2'd1, 8'h02);
    check(irq_end == 1'b1 && irq_empty == 1'b0, "R8 end only", {irq_end, irq_empty}, 2);

    // R10 external clock
    wr(2'd1, 8'h04);
    check(sclk_out == 1'b1, "R10 sclk_out idle", sclk_out, 1);
    ext_frame(8'h4B);
    ext_frame(8'hB2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule